// File: doc/BRIEF.md
# Modulo-79 Four-Operand Hop Adder

This block adds four unsigned operands and reduces the total modulo 79, the number of channels in a frequency-hopping radio. There is no divider. The sum goes into an accumulator, and 79 is subtracted from it at most once per clock until the value drops below the modulus. The reduction stops early, so a small sum finishes quickly.

A second mode reduces the sum modulo 32. In that mode the block keeps the low five bits of the sum and does not iterate. The caller pulses `start` with the operands and the mode. The block answers with `busy` while it subtracts, then a single-cycle `done` together with a valid `result`.

Top module: `hop_mod_adder`

## Requirements
- R1: With `mode`=0, the `result` presented with `done` equals (op_a+op_b+op_c+op_d) mod 79.
- R2: With `mode`=0, a sum below 79 is returned unchanged with no subtraction cycle. `done` is seen after the second rising edge, counting the edge that samples `start` as the first.
- R3: With `mode`=0, at most one subtraction of 79 happens per clock. `done` is seen after floor(sum/79)+2 rising edges counted the same way, so a sum of 508 takes 8 edges.
- R4: With `mode`=1, `result` equals the sum mod 32, which is the low five bits of the sum, zero-extended. `done` is seen after the first rising edge, and `busy` is never raised.
- R5: With `mode`=0, `busy` is high after the edge that samples `start`. It falls on the same edge that raises `done`.
- R6: `done` lasts exactly one cycle. `result` then holds its value until the next completion.
- R7: A `start` that arrives while `busy` is high is ignored. The operation in progress finishes with its own operands and latency.
- R8: A synchronous active-high `rst` clears `busy`, `done` and `result` to 0 on the next rising edge, and abandons any operation in progress.
- R9: Whenever `done` is high, `result` is below 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; sampled only while idle |
| mode | input | 1 | 0 = reduce modulo 79, 1 = reduce modulo 32 |
| op_a | input | 7 | Operand 0 |
| op_b | input | 7 | Operand 1 |
| op_c | input | 7 | Operand 2 |
| op_d | input | 7 | Operand 3 |
| busy | output | 1 | Subtraction loop in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 7 | Reduced sum, valid from `done` on |

## Verification
The bench builds the block with its default parameters: 7-bit operands, modulus 79 and a five-bit power-of-two reduction. With these values the largest sum, 508, forces the longest loop of six subtractions. The sums 78, 79, 157 and 158 sit on each side of the first two subtraction boundaries, and the latency can be checked exactly at each of those points. The mod-32 path drops the upper bits of sums up to 508, so truncation is tested with bits set above bit 4.

// File: rtl/hop_mod_pkg.sv
package hop_mod_pkg;

   typedef enum logic {
      RED_CHAN = 1'b0,
      RED_POW2 = 1'b1
   } red_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned sum_width(input int unsigned opw, input int unsigned nops);
      return opw + $clog2(nops);
   endfunction

endpackage

// File: rtl/hop_sum_tree.sv
module hop_sum_tree #(
   parameter int unsigned OPW  = 7,
   parameter int unsigned NOPS = 4,
   parameter int unsigned SUMW = 9
) (
   input  logic [NOPS-1:0][OPW-1:0] ops,
   output logic [SUMW-1:0]          sum
);

   logic [NOPS-1:0][SUMW-1:0] partial;

   generate
      for (genvar i = 0; i < NOPS; i++) begin : g_chain
         if (i == 0) begin : g_first
            assign partial[i] = SUMW'(ops[i]);
         end else begin : g_next
            assign partial[i] = partial[i-1] + SUMW'(ops[i]);
         end
      end
   endgenerate

   assign sum = partial[NOPS-1];

endmodule

// File: rtl/hop_reduce_step.sv
module hop_reduce_step #(
   parameter int unsigned SUMW    = 9,
   parameter int unsigned MODULUS = 79
) (
   input  logic [SUMW-1:0] val,
   output logic            below,
   output logic [SUMW-1:0] next
);
   import hop_mod_pkg::*;

   localparam logic [SUMW-1:0] MOD_W = SUMW'(MODULUS);

   generate
      if (is_pow2(MODULUS)) begin : g_pow2
         localparam int unsigned LB = $clog2(MODULUS);
         if (LB >= SUMW) begin : g_wide
            assign below = 1'b1;
         end else begin : g_narrow
            assign below = (val[SUMW-1:LB] == '0);
         end
      end else begin : g_cmp
         assign below = (val < MOD_W);
      end
   endgenerate

   assign next = val - MOD_W;

endmodule

// File: rtl/hop_mod_ctrl.sv
module hop_mod_ctrl #(
   parameter int unsigned SUMW = 9,
   parameter int unsigned RESW = 7
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            pow2_sel,
   input  logic [SUMW-1:0] sum,
   input  logic [RESW-1:0] pow2_res,
   input  logic            below,
   input  logic [SUMW-1:0] next,
   output logic [SUMW-1:0] acc_q,
   output logic            busy_q,
   output logic            done_q,
   output logic [RESW-1:0] res_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               if (pow2_sel) begin
                  res_q  <= pow2_res;
                  done_q <= 1'b1;
               end else begin
                  acc_q  <= sum;
                  busy_q <= 1'b1;
               end
            end
         end else if (below) begin
            res_q  <= acc_q[RESW-1:0];
            done_q <= 1'b1;
            busy_q <= 1'b0;
         end else begin
            acc_q <= next;
         end
      end
   end

endmodule

// File: rtl/hop_mod_adder.sv
module hop_mod_adder #(
   parameter int unsigned OPW       = 7,
   parameter int unsigned MODULUS   = 79,
   parameter int unsigned POW2_BITS = 5
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         start,
   input  logic                         mode,
   input  logic [OPW-1:0]               op_a,
   input  logic [OPW-1:0]               op_b,
   input  logic [OPW-1:0]               op_c,
   input  logic [OPW-1:0]               op_d,
   output logic                         busy,
   output logic                         done,
   output logic [$clog2(MODULUS)-1:0]   result
);
   import hop_mod_pkg::*;

   localparam int unsigned NOPS = 4;
   localparam int unsigned SUMW = sum_width(OPW, NOPS);
   localparam int unsigned RESW = $clog2(MODULUS);

   generate
      if (OPW < 1) begin : g_bad_opw
         $error("OPW must be at least 1");
      end
      if (MODULUS < 2) begin : g_bad_mod
         $error("MODULUS must be at least 2");
      end
      if (POW2_BITS < 1 || POW2_BITS > RESW || POW2_BITS > SUMW) begin : g_bad_p2
         $error("POW2_BITS must lie in 1..min(RESW,SUMW)");
      end
   endgenerate

   logic [NOPS-1:0][OPW-1:0] ops;
   logic [SUMW-1:0]          sum;
   logic [SUMW-1:0]          acc_q;
   logic [SUMW-1:0]          next;
   logic                     below;
   logic [RESW-1:0]          pow2_res;
   red_mode_e                mode_e;

   assign ops    = {op_d, op_c, op_b, op_a};
   assign mode_e = red_mode_e'(mode);

   generate
      if (POW2_BITS == RESW) begin : g_p2_full
         assign pow2_res = sum[RESW-1:0];
      end else begin : g_p2_pad
         assign pow2_res = {{(RESW-POW2_BITS){1'b0}}, sum[POW2_BITS-1:0]};
      end
   endgenerate

   hop_sum_tree #(.OPW(OPW), .NOPS(NOPS), .SUMW(SUMW)) u_sum (
      .ops (ops),
      .sum (sum)
   );

   hop_reduce_step #(.SUMW(SUMW), .MODULUS(MODULUS)) u_step (
      .val   (acc_q),
      .below (below),
      .next  (next)
   );

   hop_mod_ctrl #(.SUMW(SUMW), .RESW(RESW)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .pow2_sel (mode_e == RED_POW2),
      .sum      (sum),
      .pow2_res (pow2_res),
      .below    (below),
      .next     (next),
      .acc_q    (acc_q),
      .busy_q   (busy),
      .done_q   (done),
      .res_q    (result)
   );

endmodule

// File: rtl/hop_mod_adder_chk.sv
module hop_mod_adder_chk #(
   parameter int unsigned SUMW    = 9,
   parameter int unsigned RESW    = 7,
   parameter int unsigned MODULUS = 79
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [RESW-1:0] result,
   input logic [SUMW-1:0] acc_q
);

   // R9
   result_range_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (result < RESW'(MODULUS)));

   // R5
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> !done);

   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && acc_q >= SUMW'(MODULUS)) |=> (busy && acc_q == $past(acc_q) - SUMW'(MODULUS)));

   // R2
   exit_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && acc_q < SUMW'(MODULUS)) |=> (done && !busy && result == $past(acc_q[RESW-1:0])));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(result) || $past(rst));

endmodule

bind hop_mod_adder hop_mod_adder_chk #(
   .SUMW    (SUMW),
   .RESW    (RESW),
   .MODULUS (MODULUS)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result),
   .acc_q  (acc_q)
);

// File: tb/hop_mod_adder_tb.sv
module hop_mod_adder_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       mode = 1'b0;
   logic [6:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
   logic       busy, done;
   logic [6:0] result;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   hop_mod_adder u_dut (
      .clk(clk), .rst(rst), .start(start), .mode(mode),
      .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Issue one request; return the edge count to done, the result, and busy after the first edge.
   task automatic issue(input int a, input int b, input int c, input int d, input bit m,
                        output int lat, output int res, output bit busy1);
      @(negedge clk);
      op_a = 7'(a); op_b = 7'(b); op_c = 7'(c); op_d = 7'(d);
      mode = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy1 = busy;
      lat = 1;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      res = int'(result);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R8 done after reset", int'(done), 0);
      chk(result == 7'd0, "R8 result after reset", int'(result), 0);
   endtask

   task automatic t_chan(input int a, input int b, input int c, input int d, input string tag);
      int lat, res, s; bit b1;
      s = a + b + c + d;
      issue(a, b, c, d, 1'b0, lat, res, b1);
      chk(res == s % 79, {tag, " R1 result"}, res, s % 79);
      chk(lat == s / 79 + 2, {tag, " R3 latency"}, lat, s / 79 + 2);
      chk(b1 == 1'b1, {tag, " R5 busy after start"}, int'(b1), 1);
      chk(busy == 1'b0, {tag, " R5 busy falls with done"}, int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R6 done one cycle"}, int'(done), 0);
      chk(int'(result) == s % 79, {tag, " R6 result held"}, int'(result), s % 79);
   endtask

   task automatic t_small();
      int lat, res; bit b1;
      issue(20, 30, 10, 18, 1'b0, lat, res, b1);
      chk(res == 78, "R2 unchanged value", res, 78);
      chk(lat == 2, "R2 no subtraction", lat, 2);
   endtask

   task automatic t_pow2(input int a, input int b, input int c, input int d);
      int lat, res, s; bit b1;
      s = a + b + c + d;
      issue(a, b, c, d, 1'b1, lat, res, b1);
      chk(res == s % 32, "R4 mod32 result", res, s % 32);
      chk(lat == 1, "R4 mod32 latency", lat, 1);
      chk(b1 == 1'b0, "R4 busy stays low", int'(b1), 0);
   endtask

   task automatic t_busy_start();
      int lat; bit b1;
      @(negedge clk);
      op_a = 127; op_b = 127; op_c = 127; op_d = 127; mode = 0; start = 1;
      @(negedge clk);
      b1 = busy;
      op_a = 1; op_b = 2; op_c = 3; op_d = 4; mode = 1;
      @(negedge clk);
      start = 0;
      lat = 2;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(b1 == 1'b1, "R7 busy during test", int'(b1), 1);
      chk(int'(result) == 34, "R7 start ignored result", int'(result), 34);
      chk(lat == 8, "R7 start ignored latency", lat, 8);
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      op_a = 127; op_b = 127; op_c = 0; op_d = 0; mode = 0; start = 1;
      @(negedge clk);
      start = 0;
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      chk(busy == 1'b0, "R8 reset aborts busy", int'(busy), 0);
      chk(done == 1'b0, "R8 reset clears done", int'(done), 0);
      chk(result == 7'd0, "R8 reset clears result", int'(result), 0);
      repeat (6) begin
         @(negedge clk);
         chk(done == 1'b0, "R8 no late done", int'(done), 0);
      end
   endtask

   task automatic t_random();
      for (int i = 0; i < 60; i++) begin
         int a, b, c, d, lat, res, s, e; bit m, b1;
         a = int'($urandom_range(127)); b = int'($urandom_range(127));
         c = int'($urandom_range(127)); d = int'($urandom_range(127));
         m = 1'($urandom_range(1));
         s = a + b + c + d;
         issue(a, b, c, d, m, lat, res, b1);
         e = m ? s % 32 : s % 79;
         chk(res == e, m ? "R4 random result" : "R1 random result", res, e);
         chk(lat == (m ? 1 : s / 79 + 2), "R3 random latency", lat, m ? 1 : s / 79 + 2);
         chk(res < 79, "R9 range", res, 78);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_chan(0, 0, 0, 0, "sum0");
      t_chan(78, 0, 0, 0, "sum78");
      t_chan(79, 0, 0, 0, "sum79");
      t_chan(127, 30, 0, 0, "sum157");
      t_chan(127, 31, 0, 0, "sum158");
      t_chan(127, 127, 127, 127, "sum508");
      t_small();
      t_pow2(127, 127, 127, 127);
      t_pow2(31, 0, 0, 0);
      t_pow2(100, 50, 3, 0);
      t_busy_start();
      t_mid_reset();
      t_random();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule